// File: doc/BRIEF.md
# Cascadable Serial Control-Word Decoder

This block sits on a host's synchronous serial link. It takes in 16-bit words MSB first and treats each one as a control word or a data word. It holds five 8-bit configuration registers. Several copies of the block can be chained: the serial output of one feeds the serial input of the next. A control word carries a 3-bit hop count. A copy that sees a non-zero hop count lowers the count by one and sends the word on unchanged otherwise. The copy that sees zero acts on the word. A read sends the register contents back down the chain, placed in the low byte of the word.

All timing comes from the master clock `clk`. A bit strobe `bit_tick` fires once every `BIT_DIV` master cycles, and every serial bit lasts one strobe period. Reset can come from the synchronous `rst` pin or from a self-clearing bit in register 0. Register 0 also selects the operating mode. Register 2 drives the section power enables and has a global override. After any reset, the first output frame marker appears a fixed number of master cycles later.

Top module: `ctlword_chain`

## Requirements
- R1: While `rst` is high and after it, all five registers read 0x00, `ser_out`, `ser_out_fs`, `data_valid` and `sect_pwr` are low, and the block is in program mode.
- R2: `bit_tick` is high for one master cycle in every 8. Inputs are sampled on strobe cycles. An input word is marked by `ser_in_fs` high for one bit period, followed by 16 bits MSB first. Each output word is preceded by one bit period with `ser_out_fs` high, then 16 bits MSB first.
- R3: The word layout is: bit 15 is control (1) or data (0), bit 14 is read (1) or write (0), bits 13:11 are the hop count, bits 10:8 are the register select, and bits 7:0 are the payload.
- R4: A control word with a non-zero hop count, in program or mixed mode, is sent out with the hop count reduced by one and all other bits unchanged. It changes no register.
- R5: A control write with hop count 0 and select 0 to 4 loads the payload into that register.
- R6: A control read with hop count 0 and select 0 to 4 sends out the received word with its payload replaced by the register contents.
- R7: Selects 5, 6 and 7 with hop count 0 change no register and produce no output word.
- R8: Register 0 bit 0 = 0 selects program mode. Bits 1:0 = 11 select mixed mode. Bits 1:0 = 01 select data mode. In program mode a word with bit 15 = 0 is ignored. In mixed mode such a word pulses `data_valid` for one cycle with the word on `data_word`. In data mode every word is reported that way and no control word is decoded.
- R9: Writing register 0 with bit 7 set causes an internal reset lasting 4 master cycles, starting the cycle after the decode. It clears all registers. `ser_out_fs` first rises 285 cycles after the posedge that samples the word's last bit.
- R10: `ser_out_fs` first rises at the 280th posedge after reset is released, and that first frame carries 0x0000.
- R11: `sect_pwr[i]` equals register 2 bit i+1 OR register 2 bit 0.
- R12: An output word produced while a previous word is still being shifted out waits and follows it directly. No word is lost when input words arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data in, MSB first |
| ser_in_fs | input | 1 | Input frame marker, one bit period before the MSB |
| bit_tick | output | 1 | One-cycle bit strobe |
| ser_out | output | 1 | Serial data out, MSB first |
| ser_out_fs | output | 1 | Output frame marker, one bit period before the MSB |
| data_valid | output | 1 | One-cycle pulse for a received data word |
| data_word | output | 16 | Received data word |
| sect_pwr | output | 7 | Section power enables |

## Verification
Two events can fall in the same cycle. One is a new word completing in the receiver. The other is the transmitter still shifting out the previous result. When both happen, the new result must be held and then loaded at the strobe where the transmitter frees up. The bench provokes this by feeding read and forward words with no idle bit between them. It then checks that every expected word comes out, in order and unaltered. A second collision is a register-0 soft-reset write while the decode path is active. It is judged by the exact 285-cycle delay to the next frame marker and by all registers reading zero afterwards.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

    localparam int WORD_W   = 16;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 5;

    localparam logic [2:0] SEL_LIMIT   = 3'(NUM_REGS);
    localparam logic [2:0] SEL_MODE    = 3'd0;
    localparam logic [2:0] SEL_POWER   = 3'd2;
    localparam int         SOFT_BIT    = 7;
    localparam int         DSEL_BIT    = 0;
    localparam int         MIXED_BIT   = 1;
    localparam int         GLOBAL_BIT  = 0;

    typedef struct packed {
        logic       ctl;
        logic       rd;
        logic [2:0] hop;
        logic [2:0] sel;
        logic [7:0] pay;
    } ctl_word_t;

    typedef enum logic [1:0] {
        MODE_PROG  = 2'd0,
        MODE_MIXED = 2'd1,
        MODE_DATA  = 2'd2
    } op_mode_e;

    typedef struct packed {
        logic       en;
        logic [2:0] sel;
        logic [7:0] val;
    } reg_wr_t;

    typedef struct packed {
        reg_wr_t           wr;
        logic              tx_en;
        logic [WORD_W-1:0] tx_word;
        logic              dw_en;
    } dec_out_t;

    function automatic op_mode_e mode_of(input logic [REG_W-1:0] cfg);
        if (!cfg[DSEL_BIT])      return MODE_PROG;
        else if (cfg[MIXED_BIT]) return MODE_MIXED;
        else                     return MODE_DATA;
    endfunction

    function automatic ctl_word_t hop_down(input ctl_word_t w);
        ctl_word_t r;
        r     = w;
        r.hop = w.hop - 3'd1;
        return r;
    endfunction

endpackage

// File: rtl/cwc_ser_rx.sv
module cwc_ser_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sdi,
    input  logic              sfs,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    localparam int CW = $clog2(WORD_W + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            done   <= 1'b0;
            word   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (sfs) begin
                    left_q <= CW'(WORD_W);
                end else if (left_q != '0) begin
                    word   <= {word[WORD_W-2:0], sdi};
                    left_q <= left_q - 1'b1;
                    if (left_q == CW'(1)) done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cwc_ser_tx.sv
module cwc_ser_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              boot,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_word,
    output logic              sdo,
    output logic              sfs
);
    localparam int CW = $clog2(WORD_W + 1);

    logic [CW-1:0]     left_q;
    logic [WORD_W-1:0] sh_q;
    logic              pend_q;
    logic [WORD_W-1:0] pend_word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q      <= '0;
            sh_q        <= '0;
            pend_q      <= 1'b0;
            pend_word_q <= '0;
            sdo         <= 1'b0;
            sfs         <= 1'b0;
        end else begin
            if (tick) begin
                if (left_q != '0) begin
                    sfs    <= 1'b0;
                    sdo    <= sh_q[WORD_W-1];
                    sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                    left_q <= left_q - 1'b1;
                end else if (boot) begin
                    sfs    <= 1'b1;
                    sdo    <= 1'b0;
                    sh_q   <= '0;
                    left_q <= CW'(WORD_W);
                end else if (pend_q) begin
                    sfs    <= 1'b1;
                    sdo    <= 1'b0;
                    sh_q   <= pend_word_q;
                    left_q <= CW'(WORD_W);
                    pend_q <= 1'b0;
                end else begin
                    sfs <= 1'b0;
                    sdo <= 1'b0;
                end
            end
            // A new result wins over a same-cycle consume of the old one.
            if (ld_valid) begin
                pend_q      <= 1'b1;
                pend_word_q <= ld_word;
            end
        end
    end
endmodule

// File: rtl/cwc_decode.sv
module cwc_decode
    import cwc_pkg::*;
(
    input  logic              go,
    input  logic [WORD_W-1:0] word,
    input  logic [REG_W-1:0]  cfg_mode,
    input  logic [REG_W-1:0]  rd_data,
    output logic [2:0]        rd_sel,
    output dec_out_t          dec
);
    ctl_word_t w;
    ctl_word_t rsp;
    op_mode_e  mode;

    assign w      = ctl_word_t'(word);
    assign mode   = mode_of(cfg_mode);
    assign rd_sel = w.sel;

    always_comb begin
        dec     = '0;
        rsp     = w;
        rsp.pay = rd_data;
        if (go) begin
            if (mode == MODE_DATA) begin
                dec.dw_en = 1'b1;
            end else if (!w.ctl) begin
                dec.dw_en = (mode == MODE_MIXED);
            end else if (w.hop != 3'd0) begin
                dec.tx_en   = 1'b1;
                dec.tx_word = hop_down(w);
            end else if (w.sel < SEL_LIMIT) begin
                if (w.rd) begin
                    dec.tx_en   = 1'b1;
                    dec.tx_word = rsp;
                end else begin
                    dec.wr.en  = 1'b1;
                    dec.wr.sel = w.sel;
                    dec.wr.val = w.pay;
                end
            end
        end
    end
endmodule

// File: rtl/cwc_cfg_regs.sv
module cwc_cfg_regs
    import cwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    input  logic [2:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] mode_reg,
    output logic [REG_W-1:0] pwr_reg
);
    logic [NUM_REGS-1:0][REG_W-1:0] bank;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)
                r_q <= '0;
            else if (wr.en && wr.sel == 3'(g))
                r_q <= wr.val;
        end
        assign bank[g] = r_q;
    end

    assign rd_data  = (rd_sel < SEL_LIMIT) ? bank[rd_sel] : '0;
    assign mode_reg = bank[SEL_MODE];
    assign pwr_reg  = bank[SEL_POWER];
endmodule

// File: rtl/ctlword_chain.sv
module ctlword_chain
    import cwc_pkg::*;
#(
    parameter int BIT_DIV   = 8,
    parameter int START_DLY = 280,
    parameter int SRST_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              ser_in_fs,
    output logic              bit_tick,
    output logic              ser_out,
    output logic              ser_out_fs,
    output logic              data_valid,
    output logic [WORD_W-1:0] data_word,
    output logic [REG_W-2:0]  sect_pwr
);
    localparam int DW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
    localparam int SW = $clog2(START_DLY + 1);
    localparam int RW = $clog2(SRST_LEN + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(BIT_DIV - 1);
    localparam logic [SW-1:0] BOOT_AT  = SW'(START_DLY - 1);
    localparam logic [SW-1:0] START_END = SW'(START_DLY);

    logic [DW-1:0]     div_q;
    logic [SW-1:0]     start_q;
    logic [RW-1:0]     srst_q;
    logic              int_rst;
    logic              boot;
    logic              rx_done;
    logic [WORD_W-1:0] rx_word;
    logic [REG_W-1:0]  mode_reg;
    logic [REG_W-1:0]  pwr_reg;
    logic [REG_W-1:0]  rd_data;
    logic [2:0]        rd_sel;
    dec_out_t          dec;
    logic              soft_go;

    assign int_rst  = rst || (srst_q != '0);
    assign bit_tick = (div_q == DIV_LAST) && !int_rst;
    assign boot     = bit_tick && (start_q == BOOT_AT);
    assign soft_go  = dec.wr.en && (dec.wr.sel == SEL_MODE) && dec.wr.val[SOFT_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            srst_q <= '0;
        else if (soft_go)
            srst_q <= RW'(SRST_LEN);
        else if (srst_q != '0)
            srst_q <= srst_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (int_rst) begin
            div_q   <= '0;
            start_q <= '0;
        end else begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
            if (start_q != START_END) start_q <= start_q + 1'b1;
        end
    end

    cwc_ser_rx #(.WORD_W(WORD_W)) u_rx (
        .clk  (clk),
        .rst  (int_rst),
        .tick (bit_tick),
        .sdi  (ser_in),
        .sfs  (ser_in_fs),
        .done (rx_done),
        .word (rx_word)
    );

    cwc_decode u_dec (
        .go       (rx_done),
        .word     (rx_word),
        .cfg_mode (mode_reg),
        .rd_data  (rd_data),
        .rd_sel   (rd_sel),
        .dec      (dec)
    );

    cwc_cfg_regs u_regs (
        .clk      (clk),
        .rst      (int_rst),
        .wr       (dec.wr),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .mode_reg (mode_reg),
        .pwr_reg  (pwr_reg)
    );

    cwc_ser_tx #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst      (int_rst),
        .tick     (bit_tick),
        .boot     (boot),
        .ld_valid (dec.tx_en),
        .ld_word  (dec.tx_word),
        .sdo      (ser_out),
        .sfs      (ser_out_fs)
    );

    always_ff @(posedge clk) begin
        if (int_rst) begin
            data_valid <= 1'b0;
            data_word  <= '0;
        end else begin
            data_valid <= dec.dw_en;
            if (dec.dw_en) data_word <= rx_word;
        end
    end

    for (genvar s = 0; s < REG_W - 1; s++) begin : g_pwr
        assign sect_pwr[s] = pwr_reg[s+1] | pwr_reg[GLOBAL_BIT];
    end
endmodule

// File: rtl/cwc_checker.sv
module cwc_checker #(
    parameter int START_DLY = 280
) (
    input logic       clk,
    input logic       rst,
    input logic       int_rst,
    input logic       bit_tick,
    input logic       ser_out,
    input logic       ser_out_fs,
    input logic       data_valid,
    input logic [6:0] sect_pwr
);
    localparam int CW = $clog2(START_DLY + 2);

    logic [CW-1:0] since_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (int_rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            if (since_q != CW'(START_DLY + 1)) since_q <= since_q + 1'b1;
            if (ser_out_fs) seen_q <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!ser_out && !ser_out_fs && !data_valid && sect_pwr == 7'd0));

    assert_tick_single_R2: assert property (@(posedge clk) disable iff (int_rst)
        bit_tick |=> !bit_tick);

    assert_out_on_tick_R2: assert property (@(posedge clk) disable iff (int_rst)
        !$past(bit_tick) |-> ($stable(ser_out) && $stable(ser_out_fs)));

    assert_dw_pulse_R8: assert property (@(posedge clk) disable iff (int_rst)
        data_valid |=> !data_valid);

    assert_first_frame_R10: assert property (@(posedge clk) disable iff (int_rst)
        (ser_out_fs && !seen_q) |-> (since_q == CW'(START_DLY)));
endmodule

bind ctlword_chain cwc_checker #(.START_DLY(START_DLY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .int_rst    (int_rst),
    .bit_tick   (bit_tick),
    .ser_out    (ser_out),
    .ser_out_fs (ser_out_fs),
    .data_valid (data_valid),
    .sect_pwr   (sect_pwr)
);

// File: tb/sim_ctlword_chain.sv
module sim_ctlword_chain;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_in = 1'b0;
    logic        ser_in_fs = 1'b0;
    logic        bit_tick;
    logic        ser_out;
    logic        ser_out_fs;
    logic        data_valid;
    logic [15:0] data_word;
    logic [6:0]  sect_pwr;

    ctlword_chain u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .ser_in_fs(ser_in_fs),
        .bit_tick(bit_tick), .ser_out(ser_out), .ser_out_fs(ser_out_fs),
        .data_valid(data_valid), .data_word(data_word), .sect_pwr(sect_pwr)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    logic [15:0] mon_q [512];
    int          mon_n = 0;
    int          cap_left = 0;
    logic [15:0] cap_sh = '0;
    int          dw_n = 0;
    logic [15:0] dw_last = '0;

    logic [15:0] exp_q [512];
    int          exp_n = 0;
    int          exp_dw_n = 0;
    logic [15:0] exp_dw_last = '0;
    logic [7:0]  m_reg [5];

    always @(negedge clk) begin
        if (rst) begin
            cap_left = 0;
        end else begin
            if (data_valid) begin
                dw_n++;
                dw_last = data_word;
            end
            if (bit_tick) begin
                if (cap_left > 0) begin
                    cap_sh = {cap_sh[14:0], ser_out};
                    cap_left--;
                    if (cap_left == 0) begin
                        mon_q[mon_n] = cap_sh;
                        mon_n++;
                    end
                end else if (ser_out_fs) begin
                    cap_left = 16;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [15:0] mk(input bit c, input bit r, input int hop, input int sel, input int pay);
        return {c, r, 3'(hop), 3'(sel), 8'(pay)};
    endfunction

    function automatic logic [6:0] pwr_of(input logic [7:0] c);
        return c[7:1] | {7{c[0]}};
    endfunction

    task automatic model_clear;
        for (int i = 0; i < 5; i++) m_reg[i] = 8'h00;
    endtask

    task automatic model_apply(input logic [15:0] w, output bit o_has, output logic [15:0] o_w, output bit d_has);
        logic [7:0] a;
        a = m_reg[0];
        o_has = 1'b0; o_w = '0; d_has = 1'b0;
        if (a[0] && !a[1]) begin
            d_has = 1'b1;
        end else if (!w[15]) begin
            d_has = a[0];
        end else if (w[13:11] != 3'd0) begin
            o_has = 1'b1;
            o_w   = {w[15:14], w[13:11] - 3'd1, w[10:0]};
        end else if (w[10:8] < 3'd5) begin
            if (!w[14]) m_reg[w[10:8]] = w[7:0];
            else begin
                o_has = 1'b1;
                o_w   = {w[15:8], m_reg[w[10:8]]};
            end
        end
    endtask

    task automatic wait_tick;
        @(negedge clk);
        while (!bit_tick) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w);
        wait_tick;
        ser_in_fs = 1'b1;
        ser_in    = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            wait_tick;
            ser_in_fs = 1'b0;
            ser_in    = w[i];
        end
    endtask

    task automatic expect_word(input logic [15:0] w);
        exp_q[exp_n] = w;
        exp_n++;
    endtask

    task automatic queue_word(input logic [15:0] w);
        bit oh, dh;
        logic [15:0] ow;
        model_apply(w, oh, ow, dh);
        if (oh) expect_word(ow);
        if (dh) begin exp_dw_n++; exp_dw_last = w; end
        send(w);
    endtask

    task automatic compare(input string req);
        check(mon_n == exp_n, req, mon_n, exp_n);
        if (exp_n > 0 && mon_n >= exp_n)
            check(mon_q[exp_n-1] == exp_q[exp_n-1], req, mon_q[exp_n-1], exp_q[exp_n-1]);
        check(dw_n == exp_dw_n, req, dw_n, exp_dw_n);
        if (exp_dw_n > 0) check(dw_last == exp_dw_last, req, dw_last, exp_dw_last);
    endtask

    task automatic xact(input logic [15:0] w, input string req);
        queue_word(w);
        repeat (20) wait_tick;
        compare(req);
    endtask

    task automatic read_all(input string req);
        for (int s = 0; s < 5; s++) xact(mk(1, 1, 0, s, 8'hA5), req);
    endtask

    task automatic measure_first_fs(input int expv, input string req);
        int k;
        k = 0;
        do begin
            @(posedge clk);
            k++;
            @(negedge clk);
        end while (!ser_out_fs && k < 400);
        check(k == expv, req, k, expv);
        expect_word(16'h0000);
    endtask

    task automatic hard_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check(!ser_out && !ser_out_fs && !data_valid && sect_pwr == 7'd0, "R1",
              {ser_out, ser_out_fs, data_valid, sect_pwr}, 32'd0);
        model_clear;
        mon_n = 0; exp_n = 0;
        dw_n = 0; exp_dw_n = 0;
        rst = 1'b0;
        measure_first_fs(280, "R10");
        repeat (20) wait_tick;
        compare("R10 boot frame");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run;
    end

    initial begin
        logic [15:0] w;
        int r;
        r = $urandom(32'd1357);
        model_clear;
        hard_reset;

        // R1 R3 R5 R6: register values after reset, then writes and read-backs
        read_all("R1");
        xact(mk(1, 0, 0, 1, 8'h5A), "R5");
        xact(mk(1, 0, 0, 3, 8'hC3), "R5");
        xact(mk(1, 0, 0, 4, 8'hFF), "R5");
        xact(mk(1, 0, 0, 0, 8'h00), "R5");
        read_all("R6 R3");

        // R4: forwarded words, hop counts 1..7
        for (int h = 1; h < 8; h++) xact(mk(1, h[0], h, h % 5, 16 * h + 3), "R4");
        xact(mk(1, 0, 2, 1, 8'h11), "R4");
        xact(mk(1, 1, 0, 1, 8'h00), "R4 no write");

        // R7: reserved selects
        for (int s = 5; s < 8; s++) xact(mk(1, 0, 0, s, 8'hEE), "R7");
        for (int s = 5; s < 8; s++) xact(mk(1, 1, 0, s, 8'h00), "R7");
        read_all("R7");

        // R8: program mode ignores data words
        xact(mk(0, 0, 0, 1, 8'h77), "R8 program");
        xact(mk(1, 1, 0, 1, 8'h00), "R8 program");

        // R11: power enables
        xact(mk(1, 0, 0, 2, 8'h20), "R11");
        check(sect_pwr == pwr_of(8'h20), "R11", sect_pwr, pwr_of(8'h20));
        xact(mk(1, 0, 0, 2, 8'h01), "R11");
        check(sect_pwr == pwr_of(8'h01), "R11", sect_pwr, pwr_of(8'h01));
        xact(mk(1, 0, 0, 2, 8'h20), "R11");
        check(sect_pwr == 7'h10, "R11 reference bit", sect_pwr, 7'h10);

        // R8: mixed mode
        xact(mk(1, 0, 0, 0, 8'h03), "R8 mixed");
        xact(mk(0, 1, 3, 6, 8'h9C), "R8 mixed data");
        xact(mk(1, 0, 0, 4, 8'h42), "R8 mixed ctl");
        xact(mk(1, 1, 0, 4, 8'h00), "R8 mixed ctl");

        // R12: back-to-back words while output busy
        queue_word(mk(1, 1, 0, 4, 8'h00));
        queue_word(mk(1, 0, 5, 2, 8'h6B));
        queue_word(mk(1, 1, 0, 0, 8'h00));
        repeat (60) wait_tick;
        check(mon_n == exp_n, "R12", mon_n, exp_n);
        for (int i = 1; i <= 3; i++)
            check(mon_q[exp_n-i] == exp_q[exp_n-i], "R12", mon_q[exp_n-i], exp_q[exp_n-i]);

        // Random traffic in program and mixed modes
        for (int n = 0; n < 110; n++) begin
            w = 16'($urandom());
            w[13:11] = 3'($urandom_range(0, 2));
            if (w[15] && !w[14] && w[13:11] == 3'd0 && w[10:8] == 3'd0) begin
                w[7] = 1'b0;
                w[1] = w[0];
            end
            xact(w, "R4 R5 R6 R8 random");
        end
        check(sect_pwr == pwr_of(m_reg[2]), "R11 random", sect_pwr, pwr_of(m_reg[2]));

        // R9: soft reset from register 0 bit 7
        repeat (4) wait_tick;
        send(mk(1, 0, 0, 0, 8'h80));
        @(posedge clk);
        model_clear;
        measure_first_fs(285, "R9");
        repeat (20) wait_tick;
        compare("R9 boot frame");
        check(sect_pwr == 7'd0, "R9", sect_pwr, 7'd0);
        read_all("R9");

        // R8: data mode, control decoding off
        xact(mk(1, 0, 0, 2, 8'h10), "R11");
        xact(mk(1, 0, 0, 0, 8'h01), "R8 data");
        xact(mk(1, 0, 0, 2, 8'hFF), "R8 data");
        check(sect_pwr == 7'h08, "R8 data no write", sect_pwr, 7'h08);
        xact(mk(1, 1, 0, 2, 8'h00), "R8 data no read");
        xact(mk(1, 0, 4, 1, 8'h3C), "R8 data no forward");

        // R1: hardware reset leaves data mode
        hard_reset;
        check(sect_pwr == 7'd0, "R1", sect_pwr, 7'd0);
        read_all("R1");

        finish_run;
    end
endmodule